// File: doc/BRIEF.md
# Double Bus Fault Detector

This block watches the processor's exception handling and decides when a bus or address error has become unrecoverable. A bus-error, address-error or reset exception opens a critical window when it starts, and the window closes when that exception's sequence reports completion. If a real error arrives while the window is open, the block latches a halted state.

Once halted, it drives an open-drain-style halt enable. It also stops the core from starting any new bus cycle. Bus arbitration runs on its own path, so other masters keep the bus. Only an external reset leaves the halted state.

A cycle that ended in retry is not an error. Each error source has a matching retry qualifier that cancels it. Errors outside the window are ignored, for example during the handler routine or after completion. A status output shows whether the block is idle, in the window or halted.

Top module: `dbf_guard`

## Requirements
- R1: On the clock edge that samples `exc_start_i` high, the window opens if `exc_kind_i` is 0 (bus error), 1 (address error) or 2 (reset). Kind 3 (any other exception) leaves it closed. `status_o` encodes 0 = idle, 1 = window open, 2 = halted.
- R2: The window closes on the edge that samples `exc_done_i` high, and `status_o` returns to 0.
- R3: An error counts as qualified when some bit of `err_i` is high and the `retry_i` bit with the same index is low. Bit 0 is the bus error and bit 1 the address error. A qualified error sampled while the window is open sets the halted state on that edge, so `status_o` reads 2 and `halt_oe_o` reads 1.
- R4: An error sampled while the window is closed has no effect. This includes an error in the same clock as the start pulse that opens the window.
- R5: An error bit whose matching retry bit is high is not counted, so it never causes a halt.
- R6: An error sampled in the same clock as `exc_done_i` is judged against the window as it stood before that edge. If the window was open, the block halts.
- R7: The halted state holds until an edge that samples `rst_n` low. Start, done and error pulses do not change it.
- R8: `core_grant_o` equals `core_req_i` while not halted and is 0 while halted.
- R9: `ext_gnt_o` follows `ext_req_i` one clock later whether halted or not.
- R10: After reset, `status_o` is 0, `halt_oe_o` is 0 and `ext_gnt_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low external reset |
| err_i | input | ERR_SRC | Error pulses; bit 0 bus error, bit 1 address error |
| retry_i | input | ERR_SRC | Per-source retry qualifiers that cancel the matching error bit |
| exc_start_i | input | 1 | Exception processing start pulse |
| exc_kind_i | input | KIND_W | Kind of exception being started |
| exc_done_i | input | 1 | Exception sequence complete pulse |
| core_req_i | input | 1 | Core requests a new bus cycle |
| core_grant_o | output | 1 | New cycle permitted |
| ext_req_i | input | 1 | Bus request from another master |
| ext_gnt_o | output | 1 | Registered grant to the other master |
| halt_oe_o | output | 1 | Halt line drive enable (pull low when 1) |
| status_o | output | 2 | 0 idle, 1 window open, 2 halted |

## Verification
The bench uses the default parameters: two error sources, a two-bit kind code, and fatal kinds 0 to 2. With these, every kind code can be driven, including the non-fatal one. A retry on one source can be set while the other source errors, which shows the qualification is per bit. The table and the directed tests cover same-clock pairings of an error with the start pulse and with the done pulse. They also cover the halted state holding through later pulses and clearing only on reset.

// File: rtl/dbf_pkg.sv
// Shared types for the double bus fault detector.
package dbf_pkg;
    typedef enum logic [1:0] {
        DBF_IDLE   = 2'd0,
        DBF_WINDOW = 2'd1,
        DBF_HALTED = 2'd2
    } dbf_state_e;
endpackage

// File: rtl/dbf_err_qual.sv
// Error qualifier: drops each error bit whose matching retry bit is set and
// reduces the survivors to one candidate flag.
// Assumes err_i and retry_i are indexed the same way and sampled together.
module dbf_err_qual #(
    parameter int ERR_SRC = 2
) (
    input  logic [ERR_SRC-1:0] err_i,
    input  logic [ERR_SRC-1:0] retry_i,
    output logic               cand_o
);
    logic [ERR_SRC-1:0] real_err;

    for (genvar g = 0; g < ERR_SRC; g++) begin : g_src
        // A cycle that ended in retry is not an error.
        assign real_err[g] = err_i[g] & ~retry_i[g];
    end

    // Any surviving source is a candidate fault.
    assign cand_o = |real_err;
endmodule

// File: rtl/dbf_window.sv
// Critical window tracker: opens on the start of a fatal-kind exception and
// closes on sequence completion. A start in the same clock as a done wins.
// Assumes start and done arrive as single-cycle pulses.
module dbf_window #(
    parameter int                 KIND_W      = 2,
    parameter logic [2**KIND_W-1:0] FATAL_KINDS = 4'b0111
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [KIND_W-1:0] kind_i,
    input  logic              done_i,
    output logic              window_o
);
    logic kind_fatal;
    logic window_q;

    // Look up whether the starting exception kind opens the window.
    always_comb kind_fatal = FATAL_KINDS[kind_i];

    // Window flag register.
    always_ff @(posedge clk) begin
        if (!rst_n)                    window_q <= 1'b0;
        else if (start_i && kind_fatal) window_q <= 1'b1;
        else if (done_i)               window_q <= 1'b0;
    end

    assign window_o = window_q;
endmodule

// File: rtl/dbf_halt_ctl.sv
// Sticky halt latch: sets when a candidate error meets an open window as it
// stood before the edge; only reset clears it.
module dbf_halt_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic cand_i,
    input  logic window_i,
    output logic halted_o
);
    logic halted_q;

    // Halted flag register, sticky until reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                  halted_q <= 1'b0;
        else if (cand_i && window_i) halted_q <= 1'b1;
    end

    assign halted_o = halted_q;
endmodule

// File: rtl/dbf_guard.sv
// Double bus fault detector top. Combines error qualification, window
// tracking and the halt latch. It gates the core's cycle requests and
// registers the external grant independently of the halt state.
// Assumes a synchronous active-low reset and single-cycle input pulses.
module dbf_guard
    import dbf_pkg::*;
#(
    parameter int                   ERR_SRC     = 2,
    parameter int                   KIND_W      = 2,
    parameter logic [2**KIND_W-1:0] FATAL_KINDS = 4'b0111
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ERR_SRC-1:0] err_i,
    input  logic [ERR_SRC-1:0] retry_i,
    input  logic               exc_start_i,
    input  logic [KIND_W-1:0]  exc_kind_i,
    input  logic               exc_done_i,
    input  logic               core_req_i,
    output logic               core_grant_o,
    input  logic               ext_req_i,
    output logic               ext_gnt_o,
    output logic               halt_oe_o,
    output logic [1:0]         status_o
);
    logic       cand;
    logic       window;
    logic       halted;
    logic       ext_gnt_q;
    dbf_state_e state;

    dbf_err_qual #(.ERR_SRC(ERR_SRC)) u_qual (
        .err_i   (err_i),
        .retry_i (retry_i),
        .cand_o  (cand)
    );

    dbf_window #(.KIND_W(KIND_W), .FATAL_KINDS(FATAL_KINDS)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (exc_start_i),
        .kind_i   (exc_kind_i),
        .done_i   (exc_done_i),
        .window_o (window)
    );

    dbf_halt_ctl u_halt (
        .clk      (clk),
        .rst_n    (rst_n),
        .cand_i   (cand),
        .window_i (window),
        .halted_o (halted)
    );

    // Arbitration path: grant mirrors the request one clock later, halt-blind.
    always_ff @(posedge clk) begin
        if (!rst_n) ext_gnt_q <= 1'b0;
        else        ext_gnt_q <= ext_req_i;
    end

    // Status encoding; halted dominates the window.
    always_comb begin
        if (halted)      state = DBF_HALTED;
        else if (window) state = DBF_WINDOW;
        else             state = DBF_IDLE;
    end

    assign status_o     = state;
    assign halt_oe_o    = halted;
    assign core_grant_o = core_req_i & ~halted;
    assign ext_gnt_o    = ext_gnt_q;
endmodule

// File: rtl/dbf_guard_chk.sv
// Checker for dbf_guard, relating its ports over time. Bound to every instance.
module dbf_guard_chk #(
    parameter int ERR_SRC = 2,
    parameter int KIND_W  = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [ERR_SRC-1:0] err_i,
    input logic [ERR_SRC-1:0] retry_i,
    input logic               exc_start_i,
    input logic [KIND_W-1:0]  exc_kind_i,
    input logic               exc_done_i,
    input logic               core_req_i,
    input logic               core_grant_o,
    input logic               ext_req_i,
    input logic               ext_gnt_o,
    input logic               halt_oe_o,
    input logic [1:0]         status_o
);
    logic real_err;
    assign real_err = |(err_i & ~retry_i);

    AST_FATAL_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'd1 && real_err) |=> halt_oe_o);  // R3
    AST_IDLE_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'd0) |=> !halt_oe_o);  // R4
    AST_RETRY_SAFE: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_oe_o && !real_err) |=> !halt_oe_o);  // R5
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halt_oe_o |=> (halt_oe_o && status_o == 2'd2));  // R7
    AST_CORE_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        halt_oe_o |-> !core_grant_o);  // R8
    AST_ARB_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ext_req_i |=> ext_gnt_o);  // R9
    AST_ARB_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_req_i |=> !ext_gnt_o);  // R9
    AST_WINDOW_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_start_i && exc_kind_i == 2'd0) |=> (status_o != 2'd0));  // R1
endmodule

bind dbf_guard dbf_guard_chk #(.ERR_SRC(ERR_SRC), .KIND_W(KIND_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .err_i        (err_i),
    .retry_i      (retry_i),
    .exc_start_i  (exc_start_i),
    .exc_kind_i   (exc_kind_i),
    .exc_done_i   (exc_done_i),
    .core_req_i   (core_req_i),
    .core_grant_o (core_grant_o),
    .ext_req_i    (ext_req_i),
    .ext_gnt_o    (ext_gnt_o),
    .halt_oe_o    (halt_oe_o),
    .status_o     (status_o)
);

// File: tb/dbf_guard_tb_top.sv
// Self-checking bench for dbf_guard: a vector table walk, then directed tests.
module dbf_guard_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] err_i = '0;
    logic [1:0] retry_i = '0;
    logic       exc_start_i = 1'b0;
    logic [1:0] exc_kind_i = '0;
    logic       exc_done_i = 1'b0;
    logic       core_req_i = 1'b0;
    logic       core_grant_o;
    logic       ext_req_i = 1'b0;
    logic       ext_gnt_o;
    logic       halt_oe_o;
    logic [1:0] status_o;

    int checks = 0;
    int errors = 0;
    bit done_run = 1'b0;

    always #2.5 clk = ~clk;

    dbf_guard dut_i (
        .clk(clk), .rst_n(rst_n), .err_i(err_i), .retry_i(retry_i),
        .exc_start_i(exc_start_i), .exc_kind_i(exc_kind_i),
        .exc_done_i(exc_done_i), .core_req_i(core_req_i),
        .core_grant_o(core_grant_o), .ext_req_i(ext_req_i),
        .ext_gnt_o(ext_gnt_o), .halt_oe_o(halt_oe_o), .status_o(status_o)
    );

    // Fields: [10] start, [9:8] kind, [7] done, [6:5] err, [4:3] retry,
    // [2:1] expected status, [0] expected halt enable.
    localparam int NV = 12;
    localparam logic [10:0] VEC [0:NV-1] = '{
        11'b0_00_0_00_00_00_0,  // idle                        R10
        11'b0_00_0_01_00_00_0,  // error, window closed        R4
        11'b1_11_0_00_00_00_0,  // non-fatal kind start         R1
        11'b1_00_0_00_00_01_0,  // bus error exception start    R1
        11'b0_00_0_01_01_01_0,  // retried bus error            R5
        11'b0_00_1_00_00_00_0,  // completion                   R2
        11'b0_00_0_10_00_00_0,  // error in handler             R4
        11'b1_01_0_00_00_01_0,  // address error start          R1
        11'b0_00_1_00_00_00_0,  // completion                   R2
        11'b1_10_0_10_00_01_0,  // reset start plus same-clock error R4
        11'b0_00_0_10_01_10_1,  // addr error, retry on other bit    R3
        11'b0_00_1_00_00_10_1   // done while halted            R7
    };

    function automatic string vec_req(int i);
        case (i)
            0: return "R10";
            1, 6, 9: return "R4";
            2, 3, 7: return "R1";
            4: return "R5";
            5, 8: return "R2";
            10: return "R3";
            default: return "R7";
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive one clock of pulses, then sample just after the edge.
    task automatic step(logic st, logic [1:0] kd, logic dn, logic [1:0] er, logic [1:0] rt);
        @(negedge clk);
        exc_start_i = st; exc_kind_i = kd; exc_done_i = dn; err_i = er; retry_i = rt;
        @(posedge clk);
        #1;
        @(negedge clk);
        exc_start_i = 1'b0; exc_done_i = 1'b0; err_i = '0; retry_i = '0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_run) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R10: reset state
        check(status_o == 2'd0, "R10", status_o, 0);
        check(halt_oe_o == 1'b0, "R10", halt_oe_o, 0);
        check(ext_gnt_o == 1'b0, "R10", ext_gnt_o, 0);

        for (int i = 0; i < NV; i++) begin
            step(VEC[i][10], VEC[i][9:8], VEC[i][7], VEC[i][6:5], VEC[i][4:3]);
            check(status_o == VEC[i][2:1], vec_req(i), status_o, VEC[i][2:1]);
            check(halt_oe_o == VEC[i][0], vec_req(i), halt_oe_o, VEC[i][0]);
        end

        // R8 / R9: core blocked, arbitration alive while halted
        core_req_i = 1'b1; ext_req_i = 1'b1;
        #1;
        check(core_grant_o == 1'b0, "R8", core_grant_o, 0);
        @(posedge clk); #1;
        check(ext_gnt_o == 1'b1, "R9", ext_gnt_o, 1);
        @(negedge clk); ext_req_i = 1'b0;
        @(posedge clk); #1;
        check(ext_gnt_o == 1'b0, "R9", ext_gnt_o, 0);

        // R7: a new fatal start does not leave the halted state
        step(1'b1, 2'd0, 1'b0, 2'b00, 2'b00);
        check(status_o == 2'd2, "R7", status_o, 2);

        // R7: reset is the only exit
        do_reset();
        #1;
        check(status_o == 2'd0, "R7", status_o, 0);
        check(halt_oe_o == 1'b0, "R7", halt_oe_o, 0);
        check(core_grant_o == 1'b1, "R8", core_grant_o, 1);

        // R6: error in the same clock as done, window open before the edge
        step(1'b1, 2'd2, 1'b0, 2'b00, 2'b00);
        check(status_o == 2'd1, "R1", status_o, 1);
        step(1'b0, 2'd0, 1'b1, 2'b01, 2'b00);
        check(status_o == 2'd2, "R6", status_o, 2);
        check(halt_oe_o == 1'b1, "R6", halt_oe_o, 1);
        core_req_i = 1'b1; #1;
        check(core_grant_o == 1'b0, "R8", core_grant_o, 0);

        // R4: after reset, a non-fatal kind start then an error does nothing
        do_reset();
        step(1'b1, 2'd3, 1'b0, 2'b00, 2'b00);
        step(1'b0, 2'd0, 1'b0, 2'b11, 2'b00);
        check(halt_oe_o == 1'b0, "R4", halt_oe_o, 0);
        check(status_o == 2'd0, "R4", status_o, 0);

        // R5: both sources retried inside the window
        step(1'b1, 2'd1, 1'b0, 2'b00, 2'b00);
        step(1'b0, 2'd0, 1'b0, 2'b11, 2'b11);
        check(status_o == 2'd1, "R5", status_o, 1);

        done_run = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule